// File: doc/BRIEF.md
# Multi-Size Address Translation Buffer

This block is an associative cache of address translations for a 32-bit virtual address space. It holds 64 entries. Each entry maps one aligned virtual region onto a physical region of the same size, and each entry carries its own size: 1 KB, 4 KB, 64 KB or 1 MB. Because every entry keeps its own compare mask, entries of all four sizes share one array. A lookup presents a virtual address together with a write flag and a privilege flag. One cycle later the block returns one of three results: a translated physical address, an abort for a disallowed access, or a request to an external table walker when nothing matches.

The walker returns a descriptor, which is written into the array with the fill inputs. The slot that receives it comes from a free-running 6-bit shift-register sequence that steps through all 64 slot numbers. No usage history is kept. A flush input invalidates the whole array in one cycle. Software must never load two valid entries that cover the same virtual region, so the block contains no priority logic between matches.

Top module: `mpt_tlb`

## Requirements
- R1: After reset every entry is invalid and `res_vld_o`, `res_hit_o`, `res_abort_o` and `walk_req_o` are low. A lookup made before any fill misses.
- R2: A lookup presented in cycle N produces its result in cycle N+1, with `res_vld_o` high for exactly that cycle.
- R3: Size code 2'b00 selects 1 KB, 2'b01 selects 4 KB, 2'b10 selects 64 KB and 2'b11 selects 1 MB. An entry matches when it is valid and the lookup address agrees with the stored virtual base in every bit at or above the region size (bits 10, 12, 16 or 20 and up). The address one byte past the region does not match.
- R4: On a permitted hit, `res_pa_o` takes the physical base for the bits at or above the region size and the lookup address for the bits below it. The low bits of `fill_vbase_i` and `fill_pbase_i` below the region size are discarded. On a miss or an abort, `res_pa_o` is zero.
- R5: The 2-bit permission code works as follows. 2'b00 gives no access. 2'b01 allows privileged read and write, and no user access. 2'b10 allows privileged read and write, and user read only. 2'b11 allows read and write at any level. A hit whose access is not allowed raises `res_abort_o` together with `res_hit_o`, and raises no walk request.
- R6: A lookup that matches no valid entry raises `walk_req_o` for one cycle with `walk_va_o` equal to the lookup address, while `res_hit_o` and `res_abort_o` stay low.
- R7: `flush_i` invalidates every entry at the next clock edge. A fill presented in the same cycle as a flush is discarded.
- R8: The fill slot advances every cycle through a 64-state sequence, x^6+x^5+1 extended with the all-zero state. As a result, fills on 64 consecutive cycles occupy 64 distinct slots, and a 65th fill replaces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_vld_i | input | 1 | Lookup request this cycle |
| lookup_va_i | input | 32 | Virtual address to translate |
| lookup_wr_i | input | 1 | Access is a write |
| lookup_priv_i | input | 1 | Access is made in privileged mode |
| fill_vld_i | input | 1 | Write a descriptor from the walker |
| fill_size_i | input | 2 | Region size code of the descriptor |
| fill_vbase_i | input | 32 | Virtual base of the descriptor |
| fill_pbase_i | input | 32 | Physical base of the descriptor |
| fill_perm_i | input | 2 | Permission code of the descriptor |
| flush_i | input | 1 | Invalidate all entries |
| res_vld_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Lookup matched an entry |
| res_abort_o | output | 1 | Matched entry forbids this access |
| res_pa_o | output | 32 | Translated physical address |
| walk_req_o | output | 1 | Miss: table walk needed |
| walk_va_o | output | 32 | Address that missed |

## Verification
The assertions run on every cycle. They check the following:
- the one-cycle result timing;
- that hit and walk request follow the match vector of the array;
- that the offset bits pass straight into the physical address;
- that an abort never comes without a hit;
- that a flush leaves no valid entry;
- that each fill sets the valid bit of its slot;
- that the slot sequence never stands still.

Other behaviour only the bench scenarios can show:
- the exact upper-bit arithmetic of the address for each region size;
- the full permission matrix;
- that a fill is dropped under a simultaneous flush;
- the 64-distinct-slot property of the replacement sequence, together with single-victim eviction.

// File: rtl/mpt_tlb_pkg.sv
package mpt_tlb_pkg;

  localparam int VA_W = 32;

  typedef enum logic [1:0] {
    SZ_1K  = 2'b00,
    SZ_4K  = 2'b01,
    SZ_64K = 2'b10,
    SZ_1M  = 2'b11
  } region_e;

  typedef enum logic [1:0] {
    AP_NONE    = 2'b00,
    AP_PRIV    = 2'b01,
    AP_USER_RO = 2'b10,
    AP_ALL     = 2'b11
  } perm_e;

  typedef struct packed {
    logic            valid;
    region_e         size;
    perm_e           perm;
    logic [VA_W-1:0] vbase;
    logic [VA_W-1:0] pbase;
  } entry_t;

  // number of untranslated low address bits for a region size
  function automatic int unsigned offset_bits(region_e s);
    case (s)
      SZ_1K:   return 10;
      SZ_4K:   return 12;
      SZ_64K:  return 16;
      default: return 20;
    endcase
  endfunction

  // ones on the bits that take part in the tag compare
  function automatic logic [VA_W-1:0] keep_mask(region_e s);
    return {VA_W{1'b1}} << offset_bits(s);
  endfunction

  // physical upper bits joined with virtual lower bits
  function automatic logic [VA_W-1:0] splice(logic [VA_W-1:0] pbase,
                                             logic [VA_W-1:0] va,
                                             region_e s);
    logic [VA_W-1:0] m;
    m = keep_mask(s);
    return (pbase & m) | (va & ~m);
  endfunction

  function automatic logic access_ok(perm_e p, logic wr, logic priv);
    case (p)
      AP_NONE:    return 1'b0;
      AP_PRIV:    return priv;
      AP_USER_RO: return priv | ~wr;
      default:    return 1'b1;
    endcase
  endfunction

  // feedback tap mask for a shift-left sequence, output bit is msb
  function automatic logic [7:0] lfsr_taps(int w);
    case (w)
      3:       return 8'b0000_0110;
      4:       return 8'b0000_1100;
      5:       return 8'b0001_0100;
      6:       return 8'b0011_0000;
      7:       return 8'b0110_0000;
      default: return 8'b1011_1000;
    endcase
  endfunction

endpackage

// File: rtl/mpt_tlb_slot_lfsr.sv
module mpt_tlb_slot_lfsr import mpt_tlb_pkg::*; #(
  parameter int W = 6,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);

  localparam logic [7:0]   TAPS     = lfsr_taps(W);
  localparam logic [W-1:0] TAP_MASK = TAPS[W-1:0];

  logic fb;

  // extra term inserts the all-zero state so every slot number occurs
  always_comb begin
    fb = ^(state_o & TAP_MASK);
    fb = fb ^ (state_o[W-2:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= SEED;
    else        state_o <= {state_o[W-2:0], fb};
  end

endmodule

// File: rtl/mpt_tlb_cam.sv
module mpt_tlb_cam import mpt_tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               fill_vld_i,
  input  logic [IDX_W-1:0]   fill_slot_i,
  input  entry_t             fill_entry_i,
  input  logic [VA_W-1:0]    look_va_i,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] match_o,
  output entry_t             hit_entry_o
);

  entry_t ent_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    entry_t ent_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q <= '0;
      else if (flush_i)
        ent_q.valid <= 1'b0;
      else if (fill_vld_i && fill_slot_i == IDX_W'(g))
        ent_q <= fill_entry_i;
    end

    assign ent_arr[g] = ent_q;
    assign valid_o[g] = ent_q.valid;
    assign match_o[g] = ent_q.valid &&
                        (((look_va_i ^ ent_q.vbase) & keep_mask(ent_q.size)) == '0);
  end

  // and-or read: overlapping entries are illegal, so no priority
  always_comb begin
    hit_entry_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      hit_entry_o = entry_t'(hit_entry_o | ({$bits(entry_t){match_o[i]}} & ent_arr[i]));
  end

endmodule

// File: rtl/mpt_tlb_perm.sv
module mpt_tlb_perm import mpt_tlb_pkg::*; (
  input  perm_e perm_i,
  input  logic  wr_i,
  input  logic  priv_i,
  output logic  ok_o
);

  assign ok_o = access_ok(perm_i, wr_i, priv_i);

endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb import mpt_tlb_pkg::*; #(
  parameter int ENTRIES = 64,
  parameter logic [$clog2(ENTRIES)-1:0] LFSR_SEED = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lookup_vld_i,
  input  logic [31:0] lookup_va_i,
  input  logic        lookup_wr_i,
  input  logic        lookup_priv_i,
  input  logic        fill_vld_i,
  input  logic [1:0]  fill_size_i,
  input  logic [31:0] fill_vbase_i,
  input  logic [31:0] fill_pbase_i,
  input  logic [1:0]  fill_perm_i,
  input  logic        flush_i,
  output logic        res_vld_o,
  output logic        res_hit_o,
  output logic        res_abort_o,
  output logic [31:0] res_pa_o,
  output logic        walk_req_o,
  output logic [31:0] walk_va_o
);

  localparam int IDX_W = $clog2(ENTRIES);

  // named internal events, also observed by the checker
  logic [IDX_W-1:0]   fill_slot;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  entry_t             hit_entry;
  entry_t             fill_entry;
  logic               look_hit;
  logic               look_ok;
  logic [VA_W-1:0]    look_pa;

  always_comb begin
    fill_entry.valid = 1'b1;
    fill_entry.size  = region_e'(fill_size_i);
    fill_entry.perm  = perm_e'(fill_perm_i);
    fill_entry.vbase = fill_vbase_i & keep_mask(region_e'(fill_size_i));
    fill_entry.pbase = fill_pbase_i & keep_mask(region_e'(fill_size_i));
  end

  mpt_tlb_slot_lfsr #(.W(IDX_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (fill_slot)
  );

  mpt_tlb_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .fill_vld_i   (fill_vld_i),
    .fill_slot_i  (fill_slot),
    .fill_entry_i (fill_entry),
    .look_va_i    (lookup_va_i),
    .valid_o      (valid_vec),
    .match_o      (match_vec),
    .hit_entry_o  (hit_entry)
  );

  mpt_tlb_perm u_perm (
    .perm_i (hit_entry.perm),
    .wr_i   (lookup_wr_i),
    .priv_i (lookup_priv_i),
    .ok_o   (look_ok)
  );

  assign look_hit = |match_vec;
  assign look_pa  = splice(hit_entry.pbase, lookup_va_i, hit_entry.size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o   <= 1'b0;
      res_hit_o   <= 1'b0;
      res_abort_o <= 1'b0;
      res_pa_o    <= '0;
      walk_req_o  <= 1'b0;
      walk_va_o   <= '0;
    end else begin
      res_vld_o   <= lookup_vld_i;
      res_hit_o   <= lookup_vld_i && look_hit;
      res_abort_o <= lookup_vld_i && look_hit && !look_ok;
      res_pa_o    <= (lookup_vld_i && look_hit && look_ok) ? look_pa : '0;
      walk_req_o  <= lookup_vld_i && !look_hit;
      if (lookup_vld_i && !look_hit) walk_va_o <= lookup_va_i;
    end
  end

endmodule

// File: rtl/mpt_tlb_chk.sv
module mpt_tlb_chk #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lookup_vld_i,
  input logic [31:0]        lookup_va_i,
  input logic               fill_vld_i,
  input logic               flush_i,
  input logic               res_vld_o,
  input logic               res_hit_o,
  input logic               res_abort_o,
  input logic [31:0]        res_pa_o,
  input logic               walk_req_o,
  input logic [IDX_W-1:0]   fill_slot,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] match_vec
);

  a_r2_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_vld_o == $past(lookup_vld_i));

  a_r6_hit_from_match: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_hit_o == $past(lookup_vld_i && (|match_vec)));

  a_r6_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> walk_req_o == $past(lookup_vld_i && !(|match_vec)));

  a_r4_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit_o && !res_abort_o) |-> res_pa_o[9:0] == $past(lookup_va_i[9:0]));

  a_r5_abort_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    res_abort_o |-> (res_hit_o && !walk_req_o));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(flush_i) |-> valid_vec == '0);

  a_r8_fill_sets_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(fill_vld_i && !flush_i) |-> valid_vec[$past(fill_slot)]);

  a_r8_slot_advances: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> fill_slot != $past(fill_slot));

endmodule

bind mpt_tlb mpt_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lookup_vld_i (lookup_vld_i),
  .lookup_va_i  (lookup_va_i),
  .fill_vld_i   (fill_vld_i),
  .flush_i      (flush_i),
  .res_vld_o    (res_vld_o),
  .res_hit_o    (res_hit_o),
  .res_abort_o  (res_abort_o),
  .res_pa_o     (res_pa_o),
  .walk_req_o   (walk_req_o),
  .fill_slot    (fill_slot),
  .valid_vec    (valid_vec),
  .match_vec    (match_vec)
);

// File: tb/sim_mpt_tlb.sv
module sim_mpt_tlb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_vld_i = 1'b0;
  logic [31:0] lookup_va_i = '0;
  logic        lookup_wr_i = 1'b0;
  logic        lookup_priv_i = 1'b0;
  logic        fill_vld_i = 1'b0;
  logic [1:0]  fill_size_i = '0;
  logic [31:0] fill_vbase_i = '0;
  logic [31:0] fill_pbase_i = '0;
  logic [1:0]  fill_perm_i = '0;
  logic        flush_i = 1'b0;
  logic        res_vld_o, res_hit_o, res_abort_o, walk_req_o;
  logic [31:0] res_pa_o, walk_va_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic        g_vld, g_hit, g_abort, g_walk;
  logic [31:0] g_pa, g_wva;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpt_tlb u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int region_bytes(logic [1:0] sz);
    case (sz)
      2'b00: return 1024;
      2'b01: return 4096;
      2'b10: return 65536;
      default: return 1048576;
    endcase
  endfunction

  function automatic logic [31:0] exp_pa(logic [31:0] pb, logic [31:0] va, logic [1:0] sz);
    logic [31:0] low;
    low = 32'(region_bytes(sz) - 1);
    return (pb & ~low) | (va & low);
  endfunction

  function automatic logic exp_ok(logic [1:0] p, logic wr, logic priv);
    return (p == 2'b11) || (p != 2'b00 && priv) || (p == 2'b10 && !wr);
  endfunction

  task automatic lookup(logic [31:0] va, logic wr, logic priv);
    @(negedge clk);
    lookup_vld_i = 1'b1; lookup_va_i = va; lookup_wr_i = wr; lookup_priv_i = priv;
    @(negedge clk);
    lookup_vld_i = 1'b0;
    g_vld = res_vld_o; g_hit = res_hit_o; g_abort = res_abort_o;
    g_pa = res_pa_o; g_walk = walk_req_o; g_wva = walk_va_o;
  endtask

  task automatic fill(logic [31:0] vb, logic [31:0] pb, logic [1:0] sz, logic [1:0] perm);
    @(negedge clk);
    fill_vld_i = 1'b1; fill_vbase_i = vb; fill_pbase_i = pb;
    fill_size_i = sz; fill_perm_i = perm;
    @(negedge clk);
    fill_vld_i = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 res_vld after reset", 32'(res_vld_o), 0);
    check("R1 walk_req after reset", 32'(walk_req_o), 0);
    lookup(32'h1234_5678, 1'b0, 1'b1);
    check("R2 res_vld one cycle later", 32'(g_vld), 1);
    check("R1 empty array misses", 32'(g_hit), 0);
    check("R6 walk request on miss", 32'(g_walk), 1);
    check("R6 walk address", g_wva, 32'h1234_5678);
    check("R6 no abort on miss", 32'(g_abort), 0);
    @(negedge clk);
    check("R2 res_vld drops", 32'(res_vld_o), 0);
  endtask

  task automatic t_sizes();
    logic [31:0] vb [4];
    logic [31:0] pb [4];
    vb[0] = 32'h1000_0400; pb[0] = 32'hAAAA_A800;
    vb[1] = 32'h2000_3000; pb[1] = 32'h0BCD_E000;
    vb[2] = 32'h3005_0000; pb[2] = 32'h7777_0000;
    vb[3] = 32'h4030_0000; pb[3] = 32'h8AB0_0000;
    flush();
    // low junk in the bases must be discarded (R4)
    for (int k = 0; k < 4; k++)
      fill(vb[k] | 32'h0000_0123, pb[k] | 32'h0000_0301, 2'(k), 2'b11);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] va;
      va = vb[k] + 32'(region_bytes(2'(k)) - 4);
      lookup(va, 1'b1, 1'b0);
      check("R3 hit inside region", 32'(g_hit), 1);
      check("R4 physical address", g_pa, exp_pa(pb[k], va, 2'(k)));
      lookup(vb[k], 1'b0, 1'b0);
      check("R4 physical address at base", g_pa, pb[k]);
      lookup(vb[k] + 32'(region_bytes(2'(k))), 1'b0, 1'b0);
      check("R3 miss one past region", 32'(g_hit), 0);
      check("R4 pa zero on miss", g_pa, 0);
    end
  endtask

  task automatic t_perm();
    flush();
    for (int p = 0; p < 4; p++)
      fill(32'h5000_0000 + 32'(p) * 32'h1000, 32'h0900_0000 + 32'(p) * 32'h1000, 2'b01, 2'(p));
    for (int p = 0; p < 4; p++)
      for (int acc = 0; acc < 4; acc++) begin
        logic [31:0] va;
        logic ok;
        va = 32'h5000_0000 + 32'(p) * 32'h1000 + 32'h0ABC;
        ok = exp_ok(2'(p), acc[0], acc[1]);
        lookup(va, acc[0], acc[1]);
        check("R5 hit regardless of permission", 32'(g_hit), 1);
        check("R5 abort per permission code", 32'(g_abort), 32'(!ok));
        check("R5 no walk on abort", 32'(g_walk), 0);
        check("R4 pa zero unless permitted", g_pa,
              ok ? (32'h0900_0000 + 32'(p) * 32'h1000 + 32'h0ABC) : 32'h0);
      end
  endtask

  task automatic t_flush();
    flush();
    fill(32'h6100_0000, 32'h0100_0000, 2'b11, 2'b11);
    lookup(32'h6100_0040, 1'b0, 1'b0);
    check("R7 entry present before flush", 32'(g_hit), 1);
    flush();
    lookup(32'h6100_0040, 1'b0, 1'b0);
    check("R7 flush invalidates", 32'(g_hit), 0);
    check("R7 walk after flush", 32'(g_walk), 1);
    @(negedge clk);
    flush_i = 1'b1; fill_vld_i = 1'b1;
    fill_vbase_i = 32'h6200_0000; fill_pbase_i = 32'h0200_0000;
    fill_size_i = 2'b11; fill_perm_i = 2'b11;
    @(negedge clk);
    flush_i = 1'b0; fill_vld_i = 1'b0;
    lookup(32'h6200_0010, 1'b0, 1'b0);
    check("R7 fill dropped under flush", 32'(g_hit), 0);
  endtask

  task automatic t_sweep();
    int hits;
    flush();
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      fill_vld_i = 1'b1; fill_size_i = 2'b01; fill_perm_i = 2'b11;
      fill_vbase_i = 32'h7000_0000 + (32'(k) << 12);
      fill_pbase_i = 32'h0300_0000 + (32'(k) << 12);
    end
    @(negedge clk);
    fill_vld_i = 1'b0;
    hits = 0;
    for (int k = 0; k < 64; k++) begin
      lookup(32'h7000_0000 + (32'(k) << 12) + 32'h10, 1'b0, 1'b0);
      if (g_hit && g_pa == 32'h0300_0000 + (32'(k) << 12) + 32'h10) hits++;
    end
    check("R8 64 consecutive fills all resident", 32'(hits), 64);
    fill(32'h7800_0000, 32'h0400_0000, 2'b01, 2'b11);
    lookup(32'h7800_0020, 1'b0, 1'b0);
    check("R8 new fill resident", 32'(g_hit), 1);
    hits = 0;
    for (int k = 0; k < 64; k++) begin
      lookup(32'h7000_0000 + (32'(k) << 12), 1'b0, 1'b0);
      if (g_hit) hits++;
    end
    check("R8 exactly one victim", 32'(hits), 63);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_perm();
    t_flush();
    t_sweep();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule